// File: doc/BRIEF.md
# Tamper Response and Memory Clear Controller

This block is the digital side of a two-channel tamper monitor in a battery-backed clock and memory device. Each channel watches one tamper pin. The pin can be wired as a loop that is normally closed or as a switch that is normally open. It is looked at either on every clock or only on a 1 Hz tick. When the tamper condition is seen on an enabled channel, that channel raises a latched flag. The flag stays up until software disables the channel.

A tamper event on a channel can do either or both of two things, as set by that channel's clear-enable bits:

- **Internal clear.** The block zeroes a 128-byte on-chip user RAM, one byte per clock. The RAM then stays hidden from the host until that channel's enable is dropped.
- **External clear.** The block starts the shared reset pulse, which is the same pulse used for power-fail, watchdog and manual resets. It also raises an external-memory clear output for 1, 2, 4 or 8 ticks, as chosen by a 2-bit code.

All configuration fields arrive as plain input ports.

Top module: `tamper_guard`

## Requirements
- R1: A channel with enable 1 sets its tamper flag when its synchronized pin shows the tamper condition. With mode 0 (closed loop) the tamper condition is pin high. With mode 1 (open switch) it is pin low. Once set, the flag stays set whatever the pin does, until enable is 0. With enable 0 the flag is 0. Each channel acts only on its own pin and bits.
- R2: With the channel's sample-select bit at 1, the pin is looked at only in cycles where the 1 Hz tick input is high. With the bit at 0, it is looked at every cycle.
- R3: A tamper event on a channel whose enable and internal-clear bits are both 1 does the following. It raises `clr_busy` for 128 cycles. During those cycles it writes zero to every RAM address from 0 up to 127.
- R4: After such an event, `rd_data` reads 8'hFF and host writes are ignored. This lasts while the clear runs and until the triggering channel's enable returns to 0.
- R5: With the internal-clear bit at 0, a tamper event leaves the RAM contents readable and unchanged, and `clr_busy` stays low.
- R6: A tamper event on a channel whose enable and external-clear bits are both 1 raises both `ext_clr` and `rst_out`.
- R7: `ext_clr` stays high for a number of 1 Hz ticks set by `clr_width`. Code 0 gives 1 tick, code 1 gives 2, code 2 gives 4 and code 3 gives 8. `ext_clr` drops right after the last of those ticks.
- R8: A one-cycle request from any reset source gives a `rst_out` pulse of exactly 4 clock cycles. The sources are `pwr_fail`, `wdt_expire`, either bit of `man_rst`, or an external-clear tamper event, and all of them give the same pulse.
- R9: `pull_strong[c]` equals the channel's pull-strength bit when its mode is 0. It is 0 when its mode is 1, whatever the pull-strength bit is.
- R10: After reset, the flags, `clr_busy`, `ext_clr` and `rst_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tamper_pin | input | 2 | Tamper pins, one per channel, asynchronous |
| cfg_en | input | 2 | Per-channel tamper enable |
| cfg_mode | input | 2 | Per-channel mode: 0 closed loop, 1 open switch |
| cfg_sample | input | 2 | Per-channel select: 1 for 1 Hz sampling, 0 for continuous |
| cfg_pull | input | 2 | Per-channel pull-strength select |
| cfg_clr_int | input | 2 | Per-channel internal RAM clear enable |
| cfg_clr_ext | input | 2 | Per-channel external clear enable |
| clr_width | input | 2 | External clear length code |
| pwr_fail | input | 1 | Power-down reset request |
| wdt_expire | input | 1 | Watchdog reset request |
| man_rst | input | 2 | Manual reset requests |
| wr_en | input | 1 | Host RAM write strobe |
| wr_addr | input | 7 | Host RAM write address |
| wr_data | input | 8 | Host RAM write data |
| rd_addr | input | 7 | Host RAM read address |
| rd_data | output | 8 | Host RAM read data, all ones when hidden |
| tamper_flag | output | 2 | Latched tamper flags |
| pull_strong | output | 2 | Strong pull control per channel |
| clr_busy | output | 1 | Internal RAM sweep in progress |
| ext_clr | output | 1 | External memory clear output |
| rst_out | output | 1 | Combined reset output |

## Verification
The hardest state to reach is the window after an internal clear has finished but while the channel is still enabled. In that window the RAM holds zeros, yet the host must see only ones and its writes must have no effect. The bench fills the RAM with a known pattern first. It then trips a channel and tries a write while the RAM is hidden. Only after dropping the enable does it read back all 128 addresses, which shows both the sweep and the blocked write. The external clear length is checked against the code by stepping the 1 Hz tick one pulse at a time, and the reset pulse is measured in cycles for every source.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int TG_CH = 2;

  typedef enum logic [1:0] {
    PW_ONE   = 2'd0,
    PW_TWO   = 2'd1,
    PW_FOUR  = 2'd2,
    PW_EIGHT = 2'd3
  } pw_code_e;
endpackage

// File: rtl/tg_channel.sv
module tg_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic mode,
  input  logic sample,
  input  logic pin,
  output logic flag,
  output logic event_p
);
  logic [1:0] sync_q, sync_d;
  logic       flag_q, flag_d;
  logic       ev_q, ev_d;
  logic       active, look, hit;

  always_comb begin
    sync_d = {sync_q[0], pin};
    active = mode ? ~sync_q[1] : sync_q[1];
    look   = sample ? tick : 1'b1;
    hit    = en & active & look;
    flag_d = en ? (flag_q | hit) : 1'b0;
    ev_d   = hit & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      flag_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      sync_q <= sync_d;
      flag_q <= flag_d;
      ev_q   <= ev_d;
    end
  end

  assign flag    = flag_q;
  assign event_p = ev_q;

  assert_flag_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag_q);
  assert_event_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ev_q);
  assert_sample_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !tick && !flag_q) |=> !flag_q);
endmodule

// File: rtl/tg_ram_clear.sv
module tg_ram_clear #(
  parameter int NCH   = 2,
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] desel_set,
  input  logic [NCH-1:0] en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           busy
);
  logic [DW-1:0]  mem [DEPTH];
  logic           busy_q, busy_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [NCH-1:0] desel_q, desel_d;
  logic           hidden;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    if (start) begin
      busy_d = 1'b1;
      addr_d = '0;
    end else if (busy_q) begin
      if (addr_q == AW'(DEPTH - 1)) busy_d = 1'b0;
      else                          addr_d = addr_q + 1'b1;
    end
    desel_d = en & (desel_q | desel_set);
    hidden  = busy_q | (|desel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      desel_q <= '0;
    end else begin
      busy_q  <= busy_d;
      addr_q  <= addr_d;
      desel_q <= desel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q)                mem[addr_q]  <= '0;
    else if (wr_en && !hidden) mem[wr_addr] <= wr_data;
  end

  assign rd_data = hidden ? '1 : mem[rd_addr];
  assign busy    = busy_q;

  assert_sweep_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && addr_q == '0));
  assert_sweep_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && addr_q == AW'(DEPTH - 1) && !start) |=> !busy_q);

  for (genvar g = 0; g < NCH; g++) begin : g_desel_chk
    assert_hide_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |=> !desel_q[g]);
  end
endmodule

// File: rtl/tg_resp.sv
module tg_resp
  import tg_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int PW_T0 = 1,
  parameter int PW_T1 = 2,
  parameter int PW_T2 = 4,
  parameter int PW_T3 = 8,
  localparam int PW_MAX = PW_T3,
  localparam int CW = $clog2(PW_MAX + 1),
  localparam int RW = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ext_req,
  input  logic       rst_src,
  input  pw_code_e   code,
  output logic       ext_clr,
  output logic       rst_out
);
  logic [CW-1:0] pcnt_q, pcnt_d, load_val;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    unique case (code)
      PW_ONE:  load_val = CW'(PW_T0);
      PW_TWO:  load_val = CW'(PW_T1);
      PW_FOUR: load_val = CW'(PW_T2);
      default: load_val = CW'(PW_T3);
    endcase
    pcnt_d = pcnt_q;
    if (ext_req)                    pcnt_d = load_val;
    else if (tick && pcnt_q != '0)  pcnt_d = pcnt_q - 1'b1;
    rcnt_d = rcnt_q;
    if (rst_src || ext_req)         rcnt_d = RW'(RST_CYCLES);
    else if (rcnt_q != '0)          rcnt_d = rcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign ext_clr = pcnt_q != '0;
  assign rst_out = rcnt_q != '0;

  assert_ext_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |=> (ext_clr && rst_out));
  assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clr && !tick && !ext_req) |=> ext_clr);
  assert_src_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_src |=> rst_out);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int DW         = 8,
  parameter int RST_CYCLES = 4,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1hz,
  input  logic [TG_CH-1:0] tamper_pin,
  input  logic [TG_CH-1:0] cfg_en,
  input  logic [TG_CH-1:0] cfg_mode,
  input  logic [TG_CH-1:0] cfg_sample,
  input  logic [TG_CH-1:0] cfg_pull,
  input  logic [TG_CH-1:0] cfg_clr_int,
  input  logic [TG_CH-1:0] cfg_clr_ext,
  input  logic [1:0]       clr_width,
  input  logic             pwr_fail,
  input  logic             wdt_expire,
  input  logic [1:0]       man_rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [TG_CH-1:0] tamper_flag,
  output logic [TG_CH-1:0] pull_strong,
  output logic             clr_busy,
  output logic             ext_clr,
  output logic             rst_out
);
  logic             rst_meta, rst_sync_n;
  logic [TG_CH-1:0] ev;
  logic [TG_CH-1:0] int_hit, ext_hit;
  logic             rst_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  for (genvar c = 0; c < TG_CH; c++) begin : g_ch
    tg_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick    (tick_1hz),
      .en      (cfg_en[c]),
      .mode    (cfg_mode[c]),
      .sample  (cfg_sample[c]),
      .pin     (tamper_pin[c]),
      .flag    (tamper_flag[c]),
      .event_p (ev[c])
    );
  end

  always_comb begin
    int_hit     = ev & cfg_en & cfg_clr_int;
    ext_hit     = ev & cfg_en & cfg_clr_ext;
    rst_src     = pwr_fail | wdt_expire | (|man_rst);
    pull_strong = cfg_pull & ~cfg_mode;
  end

  tg_ram_clear #(.NCH(TG_CH), .DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (|int_hit),
    .desel_set (int_hit),
    .en        (cfg_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (clr_busy)
  );

  tg_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick_1hz),
    .ext_req (|ext_hit),
    .rst_src (rst_src),
    .code    (pw_code_e'(clr_width)),
    .ext_clr (ext_clr),
    .rst_out (rst_out)
  );

  assert_pull_open_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pull_strong & cfg_mode) == '0);
endmodule

// File: tb/tamper_guard_test.sv
module tamper_guard_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz;
  logic [1:0] tamper_pin, cfg_en, cfg_mode, cfg_sample, cfg_pull;
  logic [1:0] cfg_clr_int, cfg_clr_ext, clr_width, man_rst;
  logic       pwr_fail, wdt_expire, wr_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] tamper_flag, pull_strong;
  logic       clr_busy, ext_clr, rst_out;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_guard uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tamper_pin(tamper_pin),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_sample(cfg_sample),
    .cfg_pull(cfg_pull), .cfg_clr_int(cfg_clr_int), .cfg_clr_ext(cfg_clr_ext),
    .clr_width(clr_width), .pwr_fail(pwr_fail), .wdt_expire(wdt_expire),
    .man_rst(man_rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tamper_flag(tamper_flag),
    .pull_strong(pull_strong), .clr_busy(clr_busy), .ext_clr(ext_clr),
    .rst_out(rst_out)
  );

  // detection vectors: channel, mode, pin level, expected flag
  typedef struct packed { logic ch; logic mode; logic pin; logic exp; } det_vec_t;
  localparam det_vec_t DET [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0}, '{1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0}, '{1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0}, '{1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b0}, '{1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick_1hz = 1'b1;
    step(1);
    tick_1hz = 1'b0;
  endtask

  task automatic ram_write(input logic [6:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  // counts negedges with rst_out high, waiting up to 10 cycles for it to rise
  task automatic measure_rst(output int n);
    n = 0;
    for (int w = 0; w < 10 && !rst_out; w++) step(1);
    while (rst_out && n < 50) begin
      n++;
      step(1);
    end
  endtask

  task automatic fill_ram();
    for (int i = 0; i < 128; i++) ram_write(7'(i), 8'(i) ^ 8'hA5);
  endtask

  initial begin
    step(100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int errs;
    rst_n = 1'b0; tick_1hz = 1'b0; tamper_pin = '0; cfg_en = '0; cfg_mode = '0;
    cfg_sample = '0; cfg_pull = '0; cfg_clr_int = '0; cfg_clr_ext = '0;
    clr_width = '0; pwr_fail = 1'b0; wdt_expire = 1'b0; man_rst = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R10 reset state
    check("R10 flags", 32'(tamper_flag), 0);
    check("R10 busy/ext/rst", {29'd0, clr_busy, ext_clr, rst_out}, 0);

    // R1 detection table
    foreach (DET[k]) begin
      cfg_en = '0;
      cfg_mode[DET[k].ch] = DET[k].mode;
      tamper_pin[DET[k].ch] = DET[k].pin;
      step(4);
      cfg_en[DET[k].ch] = 1'b1;
      step(5);
      check($sformatf("R1 vec%0d flag", k), 32'(tamper_flag[DET[k].ch]), 32'(DET[k].exp));
      check($sformatf("R1 vec%0d other ch", k), 32'(tamper_flag[~DET[k].ch]), 0);
      cfg_en = '0;
      step(2);
    end
    cfg_mode = '0; tamper_pin = '0;
    step(3);

    // R1 flag held after pin returns to idle, released by enable
    cfg_en[0] = 1'b1; tamper_pin[0] = 1'b1;
    step(5);
    tamper_pin[0] = 1'b0;
    step(5);
    check("R1 flag held", 32'(tamper_flag[0]), 1);
    cfg_en[0] = 1'b0;
    step(2);
    check("R1 flag released", 32'(tamper_flag[0]), 0);

    // R2 sampling on tick
    cfg_sample[0] = 1'b1; cfg_en[0] = 1'b1; tamper_pin[0] = 1'b1;
    step(8);
    check("R2 no flag before tick", 32'(tamper_flag[0]), 0);
    pulse_tick();
    step(1);
    check("R2 flag after tick", 32'(tamper_flag[0]), 1);
    cfg_en = '0; cfg_sample = '0; tamper_pin = '0;
    step(3);

    // R3/R4 internal clear and hiding
    fill_ram();
    rd_addr = 7'd9;
    step(1);
    check("R3 pattern before clear", 32'(rd_data), 32'(8'd9 ^ 8'hA5));
    cfg_clr_int[0] = 1'b1; cfg_en[0] = 1'b1; tamper_pin[0] = 1'b1;
    step(6);
    check("R3 busy during sweep", 32'(clr_busy), 1);
    check("R4 hidden during sweep", 32'(rd_data), 32'hFF);
    step(140);
    check("R3 busy ends", 32'(clr_busy), 0);
    rd_addr = 7'd5;
    step(1);
    check("R4 hidden after sweep", 32'(rd_data), 32'hFF);
    ram_write(7'd5, 8'h55);
    cfg_en = '0; tamper_pin = '0; cfg_clr_int = '0;
    step(3);
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      rd_addr = 7'(i);
      #1;
      if (rd_data !== 8'h00) errs++;
    end
    check("R3 all bytes zero, R4 write blocked", 32'(errs), 0);

    // R5 no internal clear when its bit is 0
    fill_ram();
    cfg_mode[1] = 1'b1; tamper_pin[1] = 1'b1; cfg_en[1] = 1'b1;
    step(4);
    tamper_pin[1] = 1'b0;
    step(6);
    check("R5 flag set", 32'(tamper_flag[1]), 1);
    check("R5 no sweep", 32'(clr_busy), 0);
    rd_addr = 7'd7;
    step(1);
    check("R5 data kept", 32'(rd_data), 32'(8'd7 ^ 8'hA5));
    cfg_en = '0; cfg_mode = '0; tamper_pin = '0;
    step(3);

    // R6/R7/R8 external clear per width code
    for (int code = 0; code < 4; code++) begin
      clr_width = 2'(code);
      cfg_clr_ext[0] = 1'b1; cfg_en[0] = 1'b1; tamper_pin[0] = 1'b1;
      measure_rst(n);
      check($sformatf("R8 tamper reset length code%0d", code), 32'(n), 4);
      check($sformatf("R6 ext_clr high code%0d", code), 32'(ext_clr), 1);
      for (int t = 1; t < (1 << code); t++) pulse_tick();
      step(2);
      check($sformatf("R7 ext_clr before last tick code%0d", code), 32'(ext_clr), 1);
      pulse_tick();
      check($sformatf("R7 ext_clr after last tick code%0d", code), 32'(ext_clr), 0);
      cfg_en = '0; tamper_pin = '0; cfg_clr_ext = '0;
      step(3);
    end

    // R6 gated by external-clear bit
    cfg_en[1] = 1'b1; tamper_pin[1] = 1'b1;
    step(8);
    check("R6 no ext_clr when bit 0", {30'd0, ext_clr, rst_out}, 0);
    cfg_en = '0; tamper_pin = '0;
    step(3);

    // R8 other reset sources
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: pwr_fail = 1'b1;
        1: wdt_expire = 1'b1;
        2: man_rst[0] = 1'b1;
        default: man_rst[1] = 1'b1;
      endcase
      step(1);
      pwr_fail = 1'b0; wdt_expire = 1'b0; man_rst = '0;
      measure_rst(n);
      check($sformatf("R8 source%0d reset length", s), 32'(n), 4);
      step(2);
    end

    // R9 pull strength
    cfg_pull = 2'b11; cfg_mode = 2'b00;
    #1;
    check("R9 closed loop pull", 32'(pull_strong), 3);
    cfg_mode = 2'b10;
    #1;
    check("R9 open switch ignores pull", 32'(pull_strong), 1);
    cfg_pull = '0; cfg_mode = '0;
    step(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule